// File: doc/BRIEF.md
# Module Standard Register Responder

Every firmware module on the shared register bus carries the same small set of reserved registers at the top of its address map. This block answers for them. It watches the bus inputs (a board-select mask, an address, a write enable, write data and a strobe). It acts only when the module's own bit in the mask is set, and it returns read data together with a one-cycle acknowledge.

The top sixteen addresses are handled here. A read of 0xFFFF returns the code version and a write to it asks for a warm reboot. A read of 0xFFFE returns the module identity and a write to it resets the module. 0xFFFD returns the module's status word. 0xFFF0 takes the broadcast sequencer word: its lower half is held as static mode bits and its upper half is issued as one-cycle event strobes. System-wide actions need the select mask to be all ones. Every address below 0xFFF0 is passed to a local register port owned by the module.

Top module: `modreg_responder`

## Requirements
- R1: When bit SEL_BIT of `bus_sel` is clear, a strobe is not acknowledged, `loc_stb` stays low, and no pulse, strobe or mode change results.
- R2: A selected strobe (one cycle wide) gives `bus_ack` high for exactly the single cycle that follows it. `bus_rdata` is valid in that cycle and is zero in every other cycle.
- R3: A selected read of 0xFFFF returns CODE_VER (major×100+minor).
- R4: A selected read of 0xFFFE returns MODULE_ID.
- R5: A selected read of 0xFFFD returns the `mod_status` input as sampled at the strobe.
- R6: A selected write to 0xFFFF with `bus_sel` equal to 0xFF raises `sys_reboot_req` for one cycle, in the ack cycle. With any other mask the write is acknowledged and does nothing. The write data is discarded.
- R7: A selected write to 0xFFFE raises `mod_reset_pulse` for one cycle, in the ack cycle, whatever the other mask bits are. If the mask is 0xFF, `sys_reset_req` pulses in that same cycle as well.
- R8: A selected write to 0xFFF0 loads `seq_mode` with write bits 15:0 in the ack cycle. The value holds until the next such write.
- R9: The same write drives `seq_strobes` with write bits 31:16 for exactly one cycle (the ack cycle). Bit 15 of `seq_strobes` is frame start and bit 14 is line start.
- R10: A selected access below 0xFFF0 drives `loc_stb`, `loc_we`, `loc_addr` and `loc_wdata` in the strobe cycle. `loc_rdata` sampled at that edge is returned as `bus_rdata` in the ack cycle.
- R11: A read of 0xFFF0 returns `seq_mode` in bits 15:0 and zeros above. Reads of 0xFFF1 to 0xFFFC return zero, and writes to them or to 0xFFFD change nothing.
- R12: While `rst_n` is low all outputs are zero, and `seq_mode` clears to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 8 | Board-select mask |
| bus_addr | input | 16 | Register address |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_wdata | input | 32 | Write data |
| bus_stb | input | 1 | Access strobe, one cycle per access |
| bus_rdata | output | 32 | Read data, valid with ack |
| bus_ack | output | 1 | Access acknowledge |
| mod_status | input | 32 | Module status word |
| loc_stb | output | 1 | Local register port strobe |
| loc_we | output | 1 | Local register port write enable |
| loc_addr | output | 16 | Local register port address |
| loc_wdata | output | 32 | Local register port write data |
| loc_rdata | input | 32 | Local register port read data |
| mod_reset_pulse | output | 1 | One-cycle reset of this module |
| sys_reset_req | output | 1 | One-cycle system-wide reset request |
| sys_reboot_req | output | 1 | One-cycle warm reboot request |
| seq_strobes | output | 16 | Sequencer event strobes (15 frame start, 14 line start) |
| seq_mode | output | 16 | Held sequencer mode bits |

## Verification
A reset write sent with an all-ones mask makes the module reset pulse and the system reset request fall in the same cycle. The bench sends that write and checks that both pulses are high in the ack cycle and both low one cycle later. It then sends a reset write with a partial mask and checks that only the module pulse appears. A sequencer write can also put the event strobes and the new mode bits in the same cycle. The bench samples both in the ack cycle, and one cycle later it checks that the strobes have cleared while the mode value is still held.

// File: rtl/modreg_pkg.sv
// Shared constants and types for the standard register responder.
// Assumes a 16-bit register address space with the reserved block at the top.
package modreg_pkg;
    localparam int ADDR_W = 16;

    localparam logic [ADDR_W-1:0] ADR_VERSION = 16'hFFFF;
    localparam logic [ADDR_W-1:0] ADR_IDENT   = 16'hFFFE;
    localparam logic [ADDR_W-1:0] ADR_STATUS  = 16'hFFFD;
    localparam logic [ADDR_W-1:0] ADR_SEQ     = 16'hFFF0;

    typedef enum logic [2:0] {
        ACC_LOCAL   = 3'd0,
        ACC_SEQ     = 3'd1,
        ACC_STATUS  = 3'd2,
        ACC_IDENT   = 3'd3,
        ACC_VERSION = 3'd4,
        ACC_RSVD    = 3'd5
    } acc_kind_t;
endpackage

// File: rtl/modreg_decode.sv
// Address and select decode. Purely combinational.
// Assumes bus_stb is high for one cycle per access.
module modreg_decode
    import modreg_pkg::*;
#(
    parameter int SEL_W   = 8,
    parameter int SEL_BIT = 1
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic              stb,
    output logic              hit,
    output logic              all_sel,
    output acc_kind_t         kind
);
    // Own-bit qualification and the all-ones test for global actions
    always_comb begin
        hit     = stb & sel[SEL_BIT];
        all_sel = &sel;
    end

    // Classify the address into the reserved register it selects
    always_comb begin
        if (addr < ADR_SEQ)              kind = ACC_LOCAL;
        else if (addr == ADR_SEQ)        kind = ACC_SEQ;
        else if (addr == ADR_STATUS)     kind = ACC_STATUS;
        else if (addr == ADR_IDENT)      kind = ACC_IDENT;
        else if (addr == ADR_VERSION)    kind = ACC_VERSION;
        else                             kind = ACC_RSVD;
    end
endmodule

// File: rtl/modreg_seqstate.sv
// Sequencer state register: the lower half is held as mode bits and the
// upper half is issued as strobes that last exactly one clock cycle.
// Assumes DATA_W is even.
module modreg_seqstate #(
    parameter int DATA_W = 32,
    localparam int HALF  = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [HALF-1:0]   strobes,
    output logic [HALF-1:0]   mode
);
    // Latch static mode bits on each sequencer write
    always_ff @(posedge clk) begin
        if (!rst_n)     mode <= '0;
        else if (wr_en) mode <= wdata[HALF-1:0];
    end

    // Event strobes self-clear one cycle after a write
    always_ff @(posedge clk) begin
        if (!rst_n)     strobes <= '0;
        else if (wr_en) strobes <= wdata[DATA_W-1:HALF];
        else            strobes <= '0;
    end
endmodule

// File: rtl/modreg_pulses.sv
// Registered one-cycle control pulses for module reset, system reset and
// warm reboot. The write data never reaches this logic.
// Assumes the write requests are one cycle wide.
module modreg_pulses (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_reset,
    input  logic wr_reboot,
    input  logic all_sel,
    output logic mod_reset,
    output logic sys_reset,
    output logic sys_reboot
);
    // Register each request so every pulse leaves the block from a flop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mod_reset  <= 1'b0;
            sys_reset  <= 1'b0;
            sys_reboot <= 1'b0;
        end else begin
            mod_reset  <= wr_reset;
            sys_reset  <= wr_reset & all_sel;
            sys_reboot <= wr_reboot & all_sel;
        end
    end
endmodule

// File: rtl/modreg_responder.sv
// Standard register responder for one firmware module. It decodes the
// reserved top-of-map registers, forwards lower addresses to a local port,
// and acknowledges every selected access one cycle after its strobe.
// Assumes one-cycle strobes and a local port that returns read data
// combinationally in the strobe cycle.
module modreg_responder
    import modreg_pkg::*;
#(
    parameter int SEL_W     = 8,
    parameter int DATA_W    = 32,
    parameter int SEL_BIT   = 1,
    parameter int MODULE_ID = 202,
    parameter int CODE_VER  = 315,
    localparam int HALF     = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  bus_sel,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_stb,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ack,
    input  logic [DATA_W-1:0] mod_status,
    output logic              loc_stb,
    output logic              loc_we,
    output logic [ADDR_W-1:0] loc_addr,
    output logic [DATA_W-1:0] loc_wdata,
    input  logic [DATA_W-1:0] loc_rdata,
    output logic              mod_reset_pulse,
    output logic              sys_reset_req,
    output logic              sys_reboot_req,
    output logic [HALF-1:0]   seq_strobes,
    output logic [HALF-1:0]   seq_mode
);
    logic      hit;
    logic      all_sel;
    acc_kind_t kind;
    logic      wr_seq;
    logic      wr_reset;
    logic      wr_reboot;
    logic [DATA_W-1:0] rd_mux;

    modreg_decode #(
        .SEL_W   (SEL_W),
        .SEL_BIT (SEL_BIT)
    ) u_decode (
        .sel     (bus_sel),
        .addr    (bus_addr),
        .stb     (bus_stb),
        .hit     (hit),
        .all_sel (all_sel),
        .kind    (kind)
    );

    // Write qualifiers for the reserved registers
    always_comb begin
        wr_seq    = hit & bus_we & (kind == ACC_SEQ);
        wr_reset  = hit & bus_we & (kind == ACC_IDENT);
        wr_reboot = hit & bus_we & (kind == ACC_VERSION);
    end

    // Local port pass-through for addresses below the reserved block
    always_comb begin
        loc_stb   = hit & (kind == ACC_LOCAL);
        loc_we    = loc_stb & bus_we;
        loc_addr  = loc_stb ? bus_addr  : '0;
        loc_wdata = loc_stb ? bus_wdata : '0;
    end

    // Read data selection by register kind
    always_comb begin
        unique case (kind)
            ACC_LOCAL:   rd_mux = loc_rdata;
            ACC_SEQ:     rd_mux = {{(DATA_W-HALF){1'b0}}, seq_mode};
            ACC_STATUS:  rd_mux = mod_status;
            ACC_IDENT:   rd_mux = DATA_W'(MODULE_ID);
            ACC_VERSION: rd_mux = DATA_W'(CODE_VER);
            default:     rd_mux = '0;
        endcase
    end

    // Acknowledge and read data register, one cycle after the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_ack   <= 1'b0;
            bus_rdata <= '0;
        end else begin
            bus_ack   <= hit;
            bus_rdata <= (hit && !bus_we) ? rd_mux : '0;
        end
    end

    modreg_seqstate #(
        .DATA_W (DATA_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_seq),
        .wdata   (bus_wdata),
        .strobes (seq_strobes),
        .mode    (seq_mode)
    );

    modreg_pulses u_pulses (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_reset   (wr_reset),
        .wr_reboot  (wr_reboot),
        .all_sel    (all_sel),
        .mod_reset  (mod_reset_pulse),
        .sys_reset  (sys_reset_req),
        .sys_reboot (sys_reboot_req)
    );
endmodule

// File: rtl/modreg_responder_chk.sv
// Property checker for the standard register responder, bound to the top.
module modreg_responder_chk #(
    parameter int SEL_W   = 8,
    parameter int DATA_W  = 32,
    parameter int SEL_BIT = 1,
    localparam int HALF   = DATA_W / 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [SEL_W-1:0]  bus_sel,
    input logic [15:0]       bus_addr,
    input logic              bus_we,
    input logic              bus_stb,
    input logic              bus_ack,
    input logic              loc_stb,
    input logic              mod_reset_pulse,
    input logic              sys_reset_req,
    input logic              sys_reboot_req,
    input logic [HALF-1:0]   seq_strobes,
    input logic [HALF-1:0]   seq_mode
);
    logic own;
    logic seq_wr;
    assign own    = bus_stb && bus_sel[SEL_BIT];
    assign seq_wr = own && bus_we && (bus_addr == 16'hFFF0);

    // R1
    unsel_no_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel[SEL_BIT] |-> !loc_stb);

    // R2
    ack_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        own |=> bus_ack);

    // R2
    ack_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> $past(own));

    // R6
    reboot_needs_all_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reboot_req |-> $past(own && bus_we && bus_addr == 16'hFFFF && (&bus_sel)));

    // R7
    sys_reset_with_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req |-> mod_reset_pulse);

    // R7
    mod_reset_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mod_reset_pulse |-> bus_ack);

    // R8
    mode_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_wr |=> $stable(seq_mode));

    // R9
    strobe_has_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|seq_strobes) |-> $past(seq_wr));
endmodule

bind modreg_responder modreg_responder_chk #(
    .SEL_W   (SEL_W),
    .DATA_W  (DATA_W),
    .SEL_BIT (SEL_BIT)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .bus_sel         (bus_sel),
    .bus_addr        (bus_addr),
    .bus_we          (bus_we),
    .bus_stb         (bus_stb),
    .bus_ack         (bus_ack),
    .loc_stb         (loc_stb),
    .mod_reset_pulse (mod_reset_pulse),
    .sys_reset_req   (sys_reset_req),
    .sys_reboot_req  (sys_reboot_req),
    .seq_strobes     (seq_strobes),
    .seq_mode        (seq_mode)
);

// File: tb/modreg_responder_tb.sv
// Directed bench for the standard register responder (defaults: SEL_BIT 1,
// identity 202, version 315).
module modreg_responder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_sel = '0;
    logic [15:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_stb = 1'b0;
    logic [31:0] bus_rdata;
    logic        bus_ack;
    logic [31:0] mod_status = 32'h5A5A_0F0F;
    logic        loc_stb, loc_we;
    logic [15:0] loc_addr;
    logic [31:0] loc_wdata, loc_rdata;
    logic        mod_reset_pulse, sys_reset_req, sys_reboot_req;
    logic [15:0] seq_strobes, seq_mode;

    int checks = 0;
    int errors = 0;

    // Captured values: s_ = strobe cycle, a_ = ack cycle, n_ = cycle after
    logic        s_lstb, s_lwe;
    logic [15:0] s_laddr;
    logic [31:0] s_lwdata;
    logic        a_ack, a_modr, a_sysr, a_boot, n_ack, n_modr, n_sysr, n_boot;
    logic [31:0] a_rdata, n_rdata;
    logic [15:0] a_strb, a_mode, n_strb, n_mode;

    assign loc_rdata = {16'hC3C3, loc_addr};

    always #2 clk = ~clk;

    modreg_responder u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_stb(bus_stb),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack), .mod_status(mod_status),
        .loc_stb(loc_stb), .loc_we(loc_we), .loc_addr(loc_addr),
        .loc_wdata(loc_wdata), .loc_rdata(loc_rdata),
        .mod_reset_pulse(mod_reset_pulse), .sys_reset_req(sys_reset_req),
        .sys_reboot_req(sys_reboot_req), .seq_strobes(seq_strobes),
        .seq_mode(seq_mode)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic access(input logic [7:0] sel, input logic [15:0] addr,
                          input logic we, input logic [31:0] wd);
        @(negedge clk);
        bus_sel = sel; bus_addr = addr; bus_we = we; bus_wdata = wd; bus_stb = 1'b1;
        #1;
        s_lstb = loc_stb; s_lwe = loc_we; s_laddr = loc_addr; s_lwdata = loc_wdata;
        @(negedge clk);
        a_ack = bus_ack; a_rdata = bus_rdata; a_modr = mod_reset_pulse;
        a_sysr = sys_reset_req; a_boot = sys_reboot_req; a_strb = seq_strobes; a_mode = seq_mode;
        bus_stb = 1'b0; bus_we = 1'b0; bus_sel = '0; bus_addr = '0; bus_wdata = '0;
        @(negedge clk);
        n_ack = bus_ack; n_rdata = bus_rdata; n_modr = mod_reset_pulse;
        n_sysr = sys_reset_req; n_boot = sys_reboot_req; n_strb = seq_strobes; n_mode = seq_mode;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R12 ack", 32'(bus_ack), 0);
        chk("R12 rdata", bus_rdata, 0);
        chk("R12 pulses", {29'd0, mod_reset_pulse, sys_reset_req, sys_reboot_req}, 0);
        chk("R12 seq", {seq_strobes, seq_mode}, 0);
        chk("R12 local", 32'(loc_stb), 0);
    endtask

    task automatic t_ident_reads;
        access(8'h02, 16'hFFFF, 1'b0, 0);
        chk("R3 version", a_rdata, 315);
        chk("R2 ack", 32'(a_ack), 1);
        chk("R2 ack single", 32'(n_ack), 0);
        chk("R2 rdata cleared", n_rdata, 0);
        access(8'h1F, 16'hFFFE, 1'b0, 0);
        chk("R4 identity", a_rdata, 202);
        access(8'h02, 16'hFFFD, 1'b0, 0);
        chk("R5 status", a_rdata, 32'h5A5A_0F0F);
    endtask

    task automatic t_unselected;
        access(8'hFD, 16'hFFFE, 1'b1, 0);
        chk("R1 no ack", 32'(a_ack), 0);
        chk("R1 no reset", {30'd0, a_modr, a_sysr}, 0);
        access(8'h01, 16'h0040, 1'b1, 32'h1111_2222);
        chk("R1 no local", 32'(s_lstb), 0);
        access(8'h01, 16'hFFF0, 1'b1, 32'hFFFF_FFFF);
        chk("R1 no strobe", 32'(a_strb), 0);
    endtask

    task automatic t_reboot;
        access(8'hFF, 16'hFFFF, 1'b1, 32'hDEAD_BEEF);
        chk("R6 reboot", 32'(a_boot), 1);
        chk("R6 reboot ack", 32'(a_ack), 1);
        chk("R6 reboot single", 32'(n_boot), 0);
        chk("R6 no reset", {30'd0, a_modr, a_sysr}, 0);
        access(8'h7F, 16'hFFFF, 1'b1, 0);
        chk("R6 partial no reboot", 32'(a_boot), 0);
        chk("R6 partial acked", 32'(a_ack), 1);
    endtask

    task automatic t_resets;
        access(8'h06, 16'hFFFE, 1'b1, 32'hFFFF_FFFF);
        chk("R7 mod reset", 32'(a_modr), 1);
        chk("R7 no sys reset", 32'(a_sysr), 0);
        chk("R7 mod single", 32'(n_modr), 0);
        access(8'hFF, 16'hFFFE, 1'b1, 0);
        chk("R7 both same cycle", {30'd0, a_modr, a_sysr}, 3);
        chk("R7 both cleared", {30'd0, n_modr, n_sysr}, 0);
        chk("R7 no reboot", 32'(a_boot), 0);
    endtask

    task automatic t_sequencer;
        access(8'hFF, 16'hFFF0, 1'b1, 32'hC000_1234);
        chk("R9 strobes frame+line", 32'(a_strb), 32'hC000);
        chk("R9 strobes clear", 32'(n_strb), 0);
        chk("R8 mode loaded", 32'(a_mode), 32'h1234);
        chk("R8 mode held", 32'(n_mode), 32'h1234);
        access(8'h02, 16'hFFF0, 1'b0, 0);
        chk("R11 seq read", a_rdata, 32'h0000_1234);
        access(8'h02, 16'hFFF0, 1'b1, 32'h4000_0000);
        chk("R9 line only", 32'(a_strb), 32'h4000);
        chk("R8 mode reload", 32'(a_mode), 0);
    endtask

    task automatic t_reserved;
        access(8'h02, 16'hFFF5, 1'b0, 0);
        chk("R11 reserved read", a_rdata, 0);
        chk("R11 reserved ack", 32'(a_ack), 1);
        access(8'h02, 16'hFFFC, 1'b1, 32'h0000_FFFF);
        access(8'h02, 16'hFFFD, 1'b1, 32'h0000_FFFF);
        access(8'h02, 16'hFFF0, 1'b0, 0);
        chk("R11 writes ignored", a_rdata, 0);
        chk("R11 no pulses", {29'd0, a_modr, a_sysr, a_boot}, 0);
    endtask

    task automatic t_local;
        access(8'h02, 16'h0202, 1'b1, 32'hA1B2_C3D4);
        chk("R10 local stb", {30'd0, s_lstb, s_lwe}, 3);
        chk("R10 local addr", 32'(s_laddr), 32'h0202);
        chk("R10 local wdata", s_lwdata, 32'hA1B2_C3D4);
        access(8'h02, 16'hFFEF, 1'b0, 0);
        chk("R10 local read", a_rdata, 32'hC3C3_FFEF);
        chk("R10 local read we", 32'(s_lwe), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_ident_reads();
        t_unselected();
        t_reboot();
        t_resets();
        t_sequencer();
        t_reserved();
        t_local();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule